// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Model

This block is a synthesizable, clocked stand-in for a 16-bit static RAM with active-low control pins. It has a chip select, a write enable and an output enable, plus one select for each byte lane. It is meant as the memory end of a test setup for an external memory controller. On each clock edge it turns the control pins into one of four operations: standby, read, write or output-off. Reads and writes are gated lane by lane.

The shared data pin is split into three parts. There is a write-data bus, a read-data bus and a two-bit vector that tells which read lane is driving. A lane that is not driving stands for a high-impedance pin. Writes take effect on the clock edge where their conditions hold. Read data and its drive bits are registered, so they appear one cycle after the read.

The address port is 19 bits wide. The number of stored words is a parameter, and the word index is the address modulo that depth. Setting the depth to 524288 gives the full 19-bit space. The default is kept small so that the model elaborates quickly.

Top module: `lane_sram_model`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `rdata_drv` is 2'b00.
- R2: When `chip_sel_n` is 1 at an edge, `rdata_drv` is 2'b00 after that edge and no stored word changes, whatever the other pins are.
- R3: When `hi_lane_n` and `lo_lane_n` are both 1 at an edge, the block is in standby: `rdata_drv` is 2'b00 afterwards and nothing is written, even with `chip_sel_n` at 0.
- R4: A read (`chip_sel_n`=0, `wr_en_n`=1, `out_en_n`=0, at least one lane selected) sets `rdata_drv` after that edge. Bit 0 of `rdata_drv` equals the inverse of `lo_lane_n` and bit 1 equals the inverse of `hi_lane_n`.
- R5: On a read, `rdata[7:0]` carries the stored low byte and belongs to `lo_lane_n` / `rdata_drv[0]`. `rdata[15:8]` carries the stored high byte and belongs to `hi_lane_n` / `rdata_drv[1]`. Both are valid in the cycle after the read edge.
- R6: A write (`chip_sel_n`=0, `wr_en_n`=0, at least one lane selected) stores `wdata` at that edge, only in the lanes whose select is 0. The other lane keeps its old contents.
- R7: `out_en_n` has no effect on a write, and `rdata_drv` is 2'b00 after every write edge.
- R8: With `chip_sel_n`=0, `wr_en_n`=1, `out_en_n`=1 and a lane selected, the outputs are off: `rdata_drv` is 2'b00 after the edge and nothing is written.
- R9: The word index is `a_in` modulo DEPTH. A read in the cycle right after a write to the same word returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every operation is sampled on the rising edge |
| rst_n | input | 1 | Active-low reset of the read output register |
| chip_sel_n | input | 1 | Active-low chip select |
| wr_en_n | input | 1 | Active-low write enable |
| out_en_n | input | 1 | Active-low output enable |
| hi_lane_n | input | 1 | Active-low select of data bits 15:8 |
| lo_lane_n | input | 1 | Active-low select of data bits 7:0 |
| a_in | input | ADDR_W | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| rdata_drv | output | 2 | Per-lane drive flags (bit 0 low lane, bit 1 high lane); 0 stands for high impedance |

## Verification
The bench builds the block with a 19-bit address and a depth of 64 words. The small depth lets the bench fill every word and read every word back within a few hundred cycles. Random addresses over the full 19-bit range then fold onto those 64 words very often. This puts the modulo indexing and read-after-write on the same word within reach of random stimulus. It also sweeps all 32 combinations of the five control pins, which covers every don't-care combination of the operation decode.

// File: rtl/lane_sram_pkg.sv
`timescale 1ns/1ps
package lane_sram_pkg;
   localparam int LANES = 2;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2,
      OP_MUTE  = 2'd3
   } sram_op_e;
endpackage

// File: rtl/lane_sram_decode.sv
`timescale 1ns/1ps
module lane_sram_decode
   import lane_sram_pkg::*;
(
   input  logic             chip_sel_n,
   input  logic             wr_en_n,
   input  logic             out_en_n,
   input  logic             hi_lane_n,
   input  logic             lo_lane_n,
   output sram_op_e         op,
   output logic [LANES-1:0] lane_mask
);
   always_comb begin
      lane_mask = {~hi_lane_n, ~lo_lane_n};
      if (chip_sel_n || (lane_mask == '0)) op = OP_IDLE;
      else if (!wr_en_n)                   op = OP_WRITE;
      else if (!out_en_n)                  op = OP_READ;
      else                                 op = OP_MUTE;
   end
endmodule

// File: rtl/lane_sram_lane.sv
`timescale 1ns/1ps
module lane_sram_lane #(
   parameter int LANE_W = 8,
   parameter int DEPTH  = 2048,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              rd,
   input  logic [IDX_W-1:0]  idx,
   input  logic [LANE_W-1:0] wd,
   output logic [LANE_W-1:0] q,
   output logic              drv
);
   logic [LANE_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (wr) store[idx] <= wd;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q   <= '0;
         drv <= 1'b0;
      end else begin
         drv <= rd;
         if (rd) q <= store[idx];
      end
   end

   AST_RD_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && $past(wr) && ($past(idx) == idx)) |=> (q == $past(wd, 2))); // R9
endmodule

// File: rtl/lane_sram_model.sv
`timescale 1ns/1ps
module lane_sram_model
   import lane_sram_pkg::*;
#(
   parameter int ADDR_W = 19,
   parameter int LANE_W = 8,
   parameter int DEPTH  = 2048
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      chip_sel_n,
   input  logic                      wr_en_n,
   input  logic                      out_en_n,
   input  logic                      hi_lane_n,
   input  logic                      lo_lane_n,
   input  logic [ADDR_W-1:0]         a_in,
   input  logic [LANES*LANE_W-1:0]   wdata,
   output logic [LANES*LANE_W-1:0]   rdata,
   output logic [LANES-1:0]          rdata_drv
);
   localparam int IDX_W = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (IDX_W > ADDR_W) begin : g_bad_addr
      $error("DEPTH exceeds the address space");
   end
   if (LANE_W < 1) begin : g_bad_lane
      $error("LANE_W must be positive");
   end

   sram_op_e         op;
   logic [LANES-1:0] lane_mask;
   logic [IDX_W-1:0] idx;

   assign idx = a_in[IDX_W-1:0];

   if (IDX_W < ADDR_W) begin : g_fold
      logic addr_unused;
      assign addr_unused = ^a_in[ADDR_W-1:IDX_W];
   end

   lane_sram_decode u_dec (
      .chip_sel_n (chip_sel_n),
      .wr_en_n    (wr_en_n),
      .out_en_n   (out_en_n),
      .hi_lane_n  (hi_lane_n),
      .lo_lane_n  (lo_lane_n),
      .op         (op),
      .lane_mask  (lane_mask)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      lane_sram_lane #(.LANE_W(LANE_W), .DEPTH(DEPTH)) u_lane (
         .clk   (clk),
         .rst_n (rst_n),
         .wr    ((op == OP_WRITE) && lane_mask[g]),
         .rd    ((op == OP_READ)  && lane_mask[g]),
         .idx   (idx),
         .wd    (wdata[g*LANE_W +: LANE_W]),
         .q     (rdata[g*LANE_W +: LANE_W]),
         .drv   (rdata_drv[g])
      );
   end

   AST_CS_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
      chip_sel_n |=> (rdata_drv == '0)); // R2
   AST_LANE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_lane_n && lo_lane_n) |=> (rdata_drv == '0)); // R3
   AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!chip_sel_n && !wr_en_n) |=> (rdata_drv == '0)); // R7
   AST_OUT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!chip_sel_n && wr_en_n && out_en_n) |=> (rdata_drv == '0)); // R8
   AST_READ_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      (!chip_sel_n && wr_en_n && !out_en_n) |=> (rdata_drv == $past({~hi_lane_n, ~lo_lane_n}))); // R4
endmodule

// File: tb/tb_lane_sram_model.sv
`timescale 1ns/1ps
module tb_lane_sram_model;
   localparam int AW = 19;
   localparam int DP = 64;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        chip_sel_n, wr_en_n, out_en_n, hi_lane_n, lo_lane_n;
   logic [AW-1:0] a_in;
   logic [15:0] wdata, rdata;
   logic [1:0]  rdata_drv;

   always #4 clk = ~clk;

   lane_sram_model #(.ADDR_W(AW), .LANE_W(8), .DEPTH(DP)) dut (
      .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .wr_en_n(wr_en_n),
      .out_en_n(out_en_n), .hi_lane_n(hi_lane_n), .lo_lane_n(lo_lane_n),
      .a_in(a_in), .wdata(wdata), .rdata(rdata), .rdata_drv(rdata_drv)
   );

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 0;
   logic [15:0] model [DP];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic string req_of(input bit cs, input bit we, input bit oe, input bit ub, input bit lb);
      if (cs)            return "R2 chip deselected";
      if (ub && lb)      return "R3 both lanes off";
      if (!we)           return "R7 write ignores output enable";
      if (oe)            return "R8 outputs off";
      return "R4 read lane drive";
   endfunction

   task automatic apply(input bit cs, input bit we, input bit oe, input bit ub, input bit lb,
                        input logic [AW-1:0] a, input logic [15:0] d);
      int  idx;
      bit  act, wr, rd;
      @(negedge clk);
      chip_sel_n = cs; wr_en_n = we; out_en_n = oe; hi_lane_n = ub; lo_lane_n = lb;
      a_in = a; wdata = d;
      @(posedge clk);
      #1;
      idx = int'(a) % DP;
      act = !cs && !(ub && lb);
      wr  = act && !we;
      rd  = act && we && !oe;
      chk(req_of(cs, we, oe, ub, lb), {30'd0, rdata_drv}, rd ? {30'd0, ~ub, ~lb} : 32'd0);
      if (rd) begin
         if (!lb) chk("R5 low byte data", {24'd0, rdata[7:0]},  {24'd0, model[idx][7:0]});
         if (!ub) chk("R5 high byte data", {24'd0, rdata[15:8]}, {24'd0, model[idx][15:8]});
      end
      if (wr) begin
         if (!lb) model[idx][7:0]  = d[7:0];
         if (!ub) model[idx][15:8] = d[15:8];
      end
   endtask

   task automatic rd_full(input logic [AW-1:0] a);
      apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, a, 16'h0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0;
      chip_sel_n = 1'b1; wr_en_n = 1'b1; out_en_n = 1'b1; hi_lane_n = 1'b1; lo_lane_n = 1'b1;
      a_in = '0; wdata = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset drive", {30'd0, rdata_drv}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 first cycle after reset", {30'd0, rdata_drv}, 32'd0);

      // R6: fill every word with full writes
      for (int a = 0; a < DP; a++) apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, AW'(a), 16'($urandom));

      // every control combination, each followed by a full read (R2 R3 R6 R7 R8)
      for (int c = 0; c < 32; c++) begin
         apply(c[4], c[3], c[2], c[1], c[0], AW'(5), 16'($urandom));
         rd_full(AW'(5));
      end

      // R9: folded addresses and back-to-back read after write
      apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, AW'(7 + DP * 3), 16'hA55A);
      rd_full(AW'(7));
      apply(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, AW'((1 << 18) + 9), 16'h1234);
      rd_full(AW'(9));
      apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, AW'(9), 16'hBEEF);
      rd_full(AW'((1 << 17) + 9));

      // random mix
      for (int i = 0; i < 1500; i++) begin
         bit cs = ($urandom % 4) == 0;
         apply(cs, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
               AW'($urandom), 16'($urandom));
      end

      for (int a = 0; a < DP; a++) rd_full(AW'(a));

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule